// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Bank

This block collects up to 24 interrupt sources, watches each one for a rising edge, a falling edge or both, and records every detected edge as a pending status bit. Two independent active-low interrupt outputs are produced. Each output line keeps its own copy of the status bits and its own mask, so two different hosts can service the same set of sources on separate lines without disturbing each other. The edge selection is common to both lines.

Software reaches the bank through a simple byte-wide register port with a write strobe, a read strobe and an address. A control register chooses how status is cleared: either a read of a status byte clears it, or writing ones clears the addressed bits. A second control bit chooses whether an edge that arrives while its source is already pending is remembered and re-posted once the first is cleared. A write-only test register forces status bits to one on both lines.

Source inputs are asynchronous. They pass through a two-stage synchronizer, and edges are found by comparing the synchronized value with a registered copy of the previous one. A new edge in the same cycle as a clear of that bit therefore wins, and the bit stays set.

Top module: `irq_edge_bank`

## Requirements
- R1: After reset every status bit and every test state is 0, every implemented mask bit is 1 (for 12 sources the two mask bytes of a line read 0xFF and 0x0F), the control and edge-select registers read 0, and both interrupt outputs are high.
- R2: Source i has two edge-select bits in edge-select byte i/4 at bit offset (i mod 4)*2; the upper bit of the pair enables rising-edge detection and the lower bit enables falling-edge detection. An edge of a kind that is not selected sets nothing.
- R3: A selected edge on a source input sets that source's status bit on both lines, visible after the third rising clock edge that follows the input change and not after the second.
- R4: A source whose two edge-select bits are both 0 never sets its status bit from its input.
- R5: A line's output is low exactly while some status bit of that line is 1 with its mask bit 0; status bits are set whatever the mask holds, and a mask bit of 1 keeps the source off that line.
- R6: With control bit 0 set (clear-on-read), reading a status byte clears the bits of that byte on that line from the next cycle, and writes to a status byte have no effect.
- R7: With control bit 0 clear (write-one-to-clear), writing a 1 to a status bit clears it, writing 0 leaves it, and reading does not clear.
- R8: With control bit 1 set, an edge arriving while the bit is already pending is held and the bit stays set after the first clear, dropping on the following clear; with control bit 1 clear such an edge is lost.
- R9: Writing a byte to the test-set register sets the status bits whose write-data bits are 1 on both lines; bits above the last source are ignored, and the register reads 0.
- R10: An edge detected in the same cycle as a clear of that status bit leaves the bit set.
- R11: With 12 sources the map is control 0x00, edge select 0x01-0x03, line-1 status 0x04-0x05, line-1 mask 0x06-0x07, line-2 status 0x08-0x09, line-2 mask 0x0A-0x0B, test-set 0x0C-0x0D; any other address reads 0.
- R12: Clearing a status bit on one line leaves the same bit on the other line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | N_SRC | Asynchronous interrupt source inputs |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per byte written |
| reg_rd | input | 1 | Read strobe, one cycle per byte read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte, valid in the strobe cycle |
| irq1_n | output | 1 | Line-1 active-low interrupt |
| irq2_n | output | 1 | Line-2 active-low interrupt |

## Verification
The case that matters is an edge on a source landing in the very cycle that software clears that source's status bit. The bench raises a source input and issues the clearing write exactly two cycles later, so the detected edge and the write reach the status register on the same clock edge; a later read must still show the bit set, and a plain repeat of the clear without an edge must show it cleared. The same collision between a clear-on-read and a buffered second edge is judged by reading the byte three times and expecting set, set, clear.

// File: rtl/irq_edge_bank_pkg.sv
// Shared constants and helpers for the edge-triggered interrupt bank.
// Assumes byte-wide register access.
package irq_edge_bank_pkg;
    localparam int CTRL_COR_BIT = 0;   // 1: status clears on read
    localparam int CTRL_BUF_BIT = 1;   // 1: hold a second edge while pending
    localparam int CTRL_BITS    = 2;

    // Number of bytes needed to hold a given number of bits
    function automatic int bytes_for(input int bits);
        return (bits + 7) / 8;
    endfunction
endpackage

// File: rtl/ieb_edge_detect.sv
// Synchronizes the asynchronous sources and flags selected edges.
// Each source owns two select bits: upper = rising, lower = falling.
// A one-cycle hit pulse is produced per detected edge.
// Assumes inputs are held stable for at least two clock cycles.
module ieb_edge_detect #(
    parameter int N_SRC       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_in,
    input  logic [2*N_SRC-1:0]   edge_sel,
    output logic [N_SRC-1:0]     hit
);
    logic [N_SRC-1:0] sync_q [SYNC_STAGES];
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] cur;

    // Synchronizer chain plus previous-value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= src_in;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur = sync_q[SYNC_STAGES-1];

    // Per-source edge qualification against the select pair
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = (edge_sel[2*i+1] &  cur[i] & ~prev_q[i]) |
                        (edge_sel[2*i]   & ~cur[i] &  prev_q[i]);
    end
endmodule

// File: rtl/ieb_line.sv
// One interrupt output line: status, mask and second-edge buffer.
// Set requests win over clear requests in the same cycle.
// Assumes clr and ev are single-cycle request vectors from the top.
module ieb_line #(
    parameter int N_SRC = 12,
    localparam int SB   = irq_edge_bank_pkg::bytes_for(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev,
    input  logic [N_SRC-1:0] clr,
    input  logic             buf_en,
    input  logic [SB-1:0]    mask_we,
    input  logic [7:0]       wdata,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] mask,
    output logic             irq_n
);
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] mask_q;

    // Status, pending-buffer and mask register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            pend_q   <= '0;
            mask_q   <= '1;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (clr[i]) begin
                    status_q[i] <= ev[i] | pend_q[i];
                    pend_q[i]   <= 1'b0;
                end else if (ev[i]) begin
                    if (status_q[i] && buf_en) pend_q[i] <= 1'b1;
                    status_q[i] <= 1'b1;
                end
                if (mask_we[i/8]) mask_q[i] <= wdata[i%8];
            end
        end
    end

    assign status = status_q;
    assign mask   = mask_q;
    // Active-low request from any unmasked pending bit
    assign irq_n  = ~|(status_q & ~mask_q);
endmodule

// File: rtl/irq_edge_bank.sv
// Edge-triggered interrupt bank with two independent output lines.
// Holds control and edge-select registers, decodes the byte register
// port, and feeds both line instances. Assumes one strobe per cycle.
module irq_edge_bank #(
    parameter int N_SRC       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq1_n,
    output logic             irq2_n
);
    import irq_edge_bank_pkg::*;

    localparam int SB      = bytes_for(N_SRC);
    localparam int EB      = bytes_for(2 * N_SRC);
    localparam int A_EDGE  = 1;
    localparam int A_LINE0 = A_EDGE + EB;
    localparam int A_TSET  = A_LINE0 + 4 * SB;
    localparam int NLINES  = 2;

    logic [CTRL_BITS-1:0] ctrl_q;
    logic [2*N_SRC-1:0]   edge_q;
    logic [EB-1:0]        edge_we;
    logic [N_SRC-1:0]     hit;
    logic [N_SRC-1:0]     tset;
    logic [N_SRC-1:0]     ev_l  [NLINES];
    logic [N_SRC-1:0]     clr_l [NLINES];
    logic [N_SRC-1:0]     st_l  [NLINES];
    logic [N_SRC-1:0]     mk_l  [NLINES];
    logic [SB-1:0]        mwe_l [NLINES];
    logic                 irq_l [NLINES];
    logic                 cor;

    assign cor = ctrl_q[CTRL_COR_BIT];

    // Edge-select byte write enables
    always_comb begin
        for (int k = 0; k < EB; k++)
            edge_we[k] = reg_wr && (reg_addr == AW'(A_EDGE + k));
    end

    // Test-set requests, one per source, from the test byte writes
    always_comb begin
        for (int i = 0; i < N_SRC; i++)
            tset[i] = reg_wr && (reg_addr == AW'(A_TSET + i/8)) && reg_wdata[i%8];
    end

    // Control and edge-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            edge_q <= '0;
        end else begin
            if (reg_wr && reg_addr == '0) ctrl_q <= reg_wdata[CTRL_BITS-1:0];
            for (int b = 0; b < 2*N_SRC; b++)
                if (edge_we[b/8]) edge_q[b] <= reg_wdata[b%8];
        end
    end

    ieb_edge_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_sel(edge_q), .hit(hit)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam int ST_A = A_LINE0 + g * 2 * SB;
        localparam int MK_A = ST_A + SB;

        // Clear requests and mask write enables for this line
        always_comb begin
            for (int i = 0; i < N_SRC; i++) begin
                if (cor)
                    clr_l[g][i] = reg_rd && (reg_addr == AW'(ST_A + i/8));
                else
                    clr_l[g][i] = reg_wr && (reg_addr == AW'(ST_A + i/8)) && reg_wdata[i%8];
            end
            for (int k = 0; k < SB; k++)
                mwe_l[g][k] = reg_wr && (reg_addr == AW'(MK_A + k));
        end

        assign ev_l[g] = hit | tset;

        ieb_line #(.N_SRC(N_SRC)) u_line (
            .clk(clk), .rst_n(rst_n), .ev(ev_l[g]), .clr(clr_l[g]),
            .buf_en(ctrl_q[CTRL_BUF_BIT]), .mask_we(mwe_l[g]), .wdata(reg_wdata),
            .status(st_l[g]), .mask(mk_l[g]), .irq_n(irq_l[g])
        );
    end

    assign irq1_n = irq_l[0];
    assign irq2_n = irq_l[1];

    // Read data multiplexer; unmapped and write-only bytes read 0
    always_comb begin
        logic [SB*8-1:0] st_pad;
        logic [SB*8-1:0] mk_pad;
        logic [EB*8-1:0] ed_pad;
        reg_rdata = '0;
        ed_pad = (EB*8)'(edge_q);
        if (reg_addr == '0) reg_rdata = 8'(ctrl_q);
        for (int k = 0; k < EB; k++)
            if (reg_addr == AW'(A_EDGE + k)) reg_rdata = ed_pad[k*8 +: 8];
        for (int g = 0; g < NLINES; g++) begin
            st_pad = (SB*8)'(st_l[g]);
            mk_pad = (SB*8)'(mk_l[g]);
            for (int k = 0; k < SB; k++) begin
                if (reg_addr == AW'(A_LINE0 + g*2*SB + k))      reg_rdata = st_pad[k*8 +: 8];
                if (reg_addr == AW'(A_LINE0 + g*2*SB + SB + k)) reg_rdata = mk_pad[k*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/ieb_checker.sv
// Property checker for the interrupt bank, bound to the top module.
// Observes edge hits, clear requests, status, mask and outputs.
module ieb_checker #(
    parameter int N_SRC = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SRC-1:0]   hit,
    input logic [2*N_SRC-1:0] edge_q,
    input logic [N_SRC-1:0]   clr_l [2],
    input logic [N_SRC-1:0]   st_l  [2],
    input logic [N_SRC-1:0]   mk_l  [2],
    input logic               irq1_n,
    input logic               irq2_n
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq1_n && irq2_n));

    // R5
    masked_line1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mk_l[0]) |-> irq1_n);

    // R5
    masked_line2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mk_l[1]) |-> irq2_n);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // R4
        hit_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |-> (edge_q[2*i+1] || edge_q[2*i]));
        for (genvar g = 0; g < 2; g++) begin : g_ln
            // R10
            hit_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> st_l[g][i]);
            // R12
            status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_l[g][i] && !clr_l[g][i]) |=> st_l[g][i]);
        end
    end
endmodule

bind irq_edge_bank ieb_checker #(.N_SRC(N_SRC)) u_ieb_checker (
    .clk(clk), .rst_n(rst_n), .hit(hit), .edge_q(edge_q),
    .clr_l(clr_l), .st_l(st_l), .mk_l(mk_l),
    .irq1_n(irq1_n), .irq2_n(irq2_n)
);

// File: tb/irq_edge_bank_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares.
module irq_edge_bank_bench;
    localparam int N = 12;
    localparam logic [7:0] A_CTRL = 8'h00, A_ED = 8'h01, A_ST1 = 8'h04,
                           A_MK1 = 8'h06, A_ST2 = 8'h08, A_MK2 = 8'h0A,
                           A_TSET = 8'h0C;

    logic         clk = 0;
    logic         rst_n;
    logic [N-1:0] src_in;
    logic [7:0]   reg_addr, reg_wdata;
    logic         reg_wr, reg_rd;
    logic [7:0]   reg_rdata;
    logic         irq1_n, irq2_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_q [$];
    logic [7:0] adr_q [$];
    string      req_q [$];

    always #2 clk = ~clk;

    irq_edge_bank #(.N_SRC(N)) u_irq_edge_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq1_n(irq1_n), .irq2_n(irq2_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string r);
        exp_q.push_back(e); adr_q.push_back(a); req_q.push_back(r);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic chk(input logic act, input logic e, input string r);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: output level %b, expected %b", r, act, e);
        end
    endtask

    task automatic pulse(input int i);
        src_in[i] = 1; tick(3);
        src_in[i] = 0; tick(3);
    endtask

    // Monitor: compare each read strobe against the scoreboard queue
    initial forever begin
        @(negedge clk); #1;
        if (reg_rd) begin
            logic [7:0] e, a;
            string r;
            e = exp_q.pop_front(); a = adr_q.pop_front(); r = req_q.pop_front();
            n_cmp++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: addr %h read %h, expected %h", r, a, reg_rdata, e);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        src_in = '0; reg_addr = '0; reg_wdata = '0; reg_wr = 0; reg_rd = 0;
        rst_n = 0;
        tick(4);
        rst_n = 1;

        // R1 reset state, R11 map holes
        rd(A_CTRL, 8'h00, "R1");
        rd(A_ED, 8'h00, "R1");
        rd(A_ST1, 8'h00, "R1");
        rd(A_MK1, 8'hFF, "R1");
        rd(A_MK1 + 1, 8'h0F, "R1");
        rd(A_MK2 + 1, 8'h0F, "R1");
        chk(irq1_n, 1'b1, "R1");
        chk(irq2_n, 1'b1, "R1");
        rd(8'h20, 8'h00, "R11");
        rd(A_TSET + 2, 8'h00, "R11");

        // R4 no edge selected
        src_in[0] = 1; tick(3);
        rd(A_ST1, 8'h00, "R4");
        src_in[0] = 0; tick(3);

        // R2 / R3: source 0 rising (byte 0 bit 1), source 5 falling (byte 1 bit 2)
        wr(A_ED, 8'h02);
        wr(A_ED + 1, 8'h04);
        rd(A_ED + 1, 8'h04, "R11");
        src_in[0] = 1; tick(2);
        rd(A_ST1, 8'h00, "R3");
        rd(A_ST1, 8'h01, "R3");
        rd(A_ST2, 8'h01, "R5");
        chk(irq1_n, 1'b1, "R5");
        src_in[0] = 0; tick(3);
        rd(A_ST1, 8'h01, "R2");
        src_in[5] = 1; tick(3);
        rd(A_ST1, 8'h01, "R2");
        src_in[5] = 0; tick(3);
        rd(A_ST1, 8'h21, "R2");

        // R5 mask per line
        wr(A_MK1, 8'hFE);
        chk(irq1_n, 1'b0, "R5");
        chk(irq2_n, 1'b1, "R5");

        // R7 write-one-to-clear, R12 line independence
        rd(A_ST1, 8'h21, "R7");
        wr(A_ST1, 8'h01);
        rd(A_ST1, 8'h20, "R7");
        rd(A_ST2, 8'h21, "R12");
        chk(irq1_n, 1'b1, "R5");

        // R6 clear-on-read
        wr(A_CTRL, 8'h01);
        wr(A_ST1, 8'h20);
        rd(A_ST1, 8'h20, "R6");
        rd(A_ST1, 8'h00, "R6");
        rd(A_ST2, 8'h21, "R12");
        rd(A_ST2, 8'h00, "R6");

        // R9 test-set, including bits above source 11
        wr(A_TSET + 1, 8'h08);
        rd(A_ST1 + 1, 8'h08, "R9");
        rd(A_ST2 + 1, 8'h08, "R9");
        wr(A_TSET + 1, 8'hF0);
        rd(A_ST1 + 1, 8'h00, "R9");
        rd(A_TSET, 8'h00, "R9");

        // R8 second edge dropped without buffering
        pulse(0); pulse(0);
        rd(A_ST1, 8'h01, "R8");
        rd(A_ST1, 8'h00, "R8");
        rd(A_ST2, 8'h01, "R8");
        rd(A_ST2, 8'h00, "R8");

        // R8 second edge buffered
        wr(A_CTRL, 8'h03);
        pulse(0); pulse(0);
        rd(A_ST1, 8'h01, "R8");
        rd(A_ST1, 8'h01, "R8");
        rd(A_ST1, 8'h00, "R8");
        rd(A_ST2, 8'h01, "R8");
        rd(A_ST2, 8'h01, "R8");
        rd(A_ST2, 8'h00, "R8");

        // R10 edge and clear on the same clock edge
        wr(A_CTRL, 8'h00);
        wr(A_TSET, 8'h01);
        rd(A_ST1, 8'h01, "R9");
        src_in[0] = 1; tick(2);
        wr(A_ST1, 8'h01);
        rd(A_ST1, 8'h01, "R10");
        wr(A_ST1, 8'h01);
        rd(A_ST1, 8'h00, "R10");
        src_in[0] = 0; tick(3);

        tick(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule